// File: doc/BRIEF.md
# Host-Clock-Paced Serial Master

This block is a secondary serial master whose every timing step comes from an upstream host serial clock instead of a local divider. A small command port opens a chip-select window, moves whole bytes full duplex (each byte either driven onto the shared data line or only read back from it), and closes the window. The host clock arrives already synchronized to the system clock `clk`. The block turns its rising and falling edges into the outgoing clock, data and select lines. Every setup, hold and spacing interval is therefore a whole number of host periods plus the host high or low time.

The outgoing clock idles high. Each bit runs through a fixed cycle of four host edges. Command codes on `cmd_op_i` are: 0 no-op, 1 open, 2 write byte, 3 read byte, 4 close. Any other value is consumed and ignored.

The controller has nine states:
- ST_IDLE: select high.
- ST_ARM: waits for a host falling edge to lower select.
- ST_SEL: select low, waiting for a command.
- ST_FALL_WAIT: waits for a host rise to drop the clock.
- ST_DRIVE_WAIT: waits for a host fall to drive the next bit.
- ST_RISE_WAIT: waits for a host rise to raise the clock and sample.
- ST_HOLD_WAIT: waits for a host fall that closes the bit.
- ST_TAIL: counts host falls before raising select.
- ST_GAP: counts host falls of select-high spacing.

Transitions are:
- ST_IDLE to ST_ARM on an open.
- ST_ARM to ST_SEL on a host fall.
- ST_SEL to ST_FALL_WAIT on a write or read.
- ST_SEL to ST_TAIL on a close.
- ST_FALL_WAIT to ST_DRIVE_WAIT on a host rise.
- ST_DRIVE_WAIT to ST_RISE_WAIT on a host fall.
- ST_RISE_WAIT to ST_HOLD_WAIT on a host rise.
- ST_HOLD_WAIT to ST_FALL_WAIT on a host fall, or to ST_SEL on the host fall of the last bit.
- ST_TAIL to ST_GAP on the last counted fall.
- ST_GAP to ST_IDLE on the last counted fall.

Top module: `spim_host_paced`

## Requirements
- R1: After reset `csbm_o`=1, `sckm_o`=1, `sdiom_oe_o`=0, `rx_valid_o`=0 and `cmd_ready_o`=1.
- R2: An open (code 1) accepted in idle lowers `csbm_o` on the next host falling edge. Every output change happens one `clk` cycle after the host edge that causes it.
- R3: With a transfer already pending, the first `sckm_o` fall comes one host edge (the host low time) after `csbm_o` falls, and the first rise comes three host edges after it.
- R4: `sckm_o` changes only on host rising edges, staying low for exactly one host period and high for one host period within a transfer.
- R5: `sdiom_o` changes only on the host falling edge that follows an `sckm_o` fall. It is thus valid one host low time before the rise and held one host period plus one host high time after it.
- R6: Bytes are sent most significant bit first.
- R7: `sdiom_i` is sampled on each `sckm_o` rise, MSB first. The byte appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse once the last bit's hold edge has passed.
- R8: A close (code 4) issued right after a byte raises `csbm_o` five host periods plus one host high time (11 host edges) after the last `sckm_o` rise.
- R9: `csbm_o` stays high for at least three host periods (6 host edges) before it falls again.
- R10: `sdiom_oe_o` is 1 for a write (code 2) and 0 for a read (code 3), switching on the first data edge of the byte. It is 0 whenever `csbm_o` is high.
- R11: `cmd_ready_o` is high only while idle or selected. A no-op, an open while selected, or a write, read or close while idle is consumed with no effect on any output.
- R12: `sckm_o` is high whenever `csbm_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sck_i | input | 1 | Synchronized upstream host serial clock |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 3 | Command code (0 nop, 1 open, 2 write, 3 read, 4 close) |
| cmd_data_i | input | DATA_W | Byte to send for a write |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| sckm_o | output | 1 | Outgoing serial clock, idle high |
| csbm_o | output | 1 | Outgoing active-low chip select |
| sdiom_o | output | 1 | Outgoing data bit |
| sdiom_oe_o | output | 1 | Drive enable for the data line |
| sdiom_i | input | 1 | Incoming data bit |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle pulse when a byte completes |

## Verification
A wrong state in the bit cycle shows up within a single host edge. It appears as an outgoing clock or data transition on the wrong host edge parity, or as an edge-count distance other than one, two or three. A wrong tail or gap count moves the select rise or the next select fall by a multiple of two host edges, so it appears on the first close. A broken shift or sample path corrupts the byte caught by the slave model or the one returned on `rx_data_o`, and this is reported when that byte completes.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_OPEN  = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_CLOSE = 3'd4
    } spim_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARM,
        ST_SEL,
        ST_FALL_WAIT,
        ST_DRIVE_WAIT,
        ST_RISE_WAIT,
        ST_HOLD_WAIT,
        ST_TAIL,
        ST_GAP
    } spim_state_e;

endpackage

// File: rtl/spim_host_edge.sv
module spim_host_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic host_sck_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= host_sck_i;
    end

    assign rise_o = host_sck_i & ~prev_q;
    assign fall_o = ~host_sck_i & prev_q;
endmodule

// File: rtl/spim_tick_counter.sv
module spim_tick_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    assign last_o = tick_i && (cnt_q == limit_i - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (tick_i)     cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              drive_i,
    input  logic              sample_i,
    input  logic              sample_bit_i,
    output logic              mosi_o,
    output logic [DATA_W-1:0] rx_word_o
);
    logic [DATA_W-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q      <= '0;
            mosi_o    <= 1'b0;
            rx_word_o <= '0;
        end else begin
            if (load_i) begin
                tx_q <= load_data_i;
            end else if (drive_i) begin
                mosi_o <= tx_q[DATA_W-1];
                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
            end
            if (sample_i) rx_word_o <= {rx_word_o[DATA_W-2:0], sample_bit_i};
        end
    end
endmodule

// File: rtl/spim_host_paced.sv
module spim_host_paced
    import spim_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int TAIL_PERIODS = 5,
    parameter int GAP_PERIODS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sck_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    output logic              cmd_ready_o,
    output logic              sckm_o,
    output logic              csbm_o,
    output logic              sdiom_o,
    output logic              sdiom_oe_o,
    input  logic              sdiom_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o
);
    localparam int BIT_W   = $clog2(DATA_W + 1);
    localparam int TAIL_W  = $clog2(TAIL_PERIODS + 1);
    localparam int GAP_LIM = (GAP_PERIODS > 1) ? GAP_PERIODS - 1 : 1;
    localparam int GAP_W   = $clog2(GAP_LIM + 1);

    spim_state_e state_q, state_d;
    logic host_rise, host_fall;
    logic accept, take_xfer, take_close;
    logic bit_last, tail_last, gap_last;
    logic wr_mode_q;
    logic [DATA_W-1:0] rx_word;

    spim_host_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sck_i (host_sck_i),
        .rise_o     (host_rise),
        .fall_o     (host_fall)
    );

    assign cmd_ready_o = (state_q == ST_IDLE) || (state_q == ST_SEL);
    assign accept      = cmd_valid_i && cmd_ready_o;
    assign take_xfer   = accept && (state_q == ST_SEL) &&
                         (cmd_op_i == OP_WRITE || cmd_op_i == OP_READ);
    assign take_close  = accept && (state_q == ST_SEL) && (cmd_op_i == OP_CLOSE);

    spim_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (take_xfer),
        .load_data_i  (cmd_data_i),
        .drive_i      (state_q == ST_DRIVE_WAIT && host_fall),
        .sample_i     (state_q == ST_RISE_WAIT && host_rise),
        .sample_bit_i (sdiom_i),
        .mosi_o       (sdiom_o),
        .rx_word_o    (rx_word)
    );

    spim_tick_counter #(.CNT_W(BIT_W)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (take_xfer),
        .tick_i  (state_q == ST_HOLD_WAIT && host_fall),
        .limit_i (BIT_W'(DATA_W)),
        .last_o  (bit_last)
    );

    spim_tick_counter #(.CNT_W(TAIL_W)) u_tail (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (take_close),
        .tick_i  (state_q == ST_TAIL && host_fall),
        .limit_i (TAIL_W'(TAIL_PERIODS)),
        .last_o  (tail_last)
    );

    spim_tick_counter #(.CNT_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tail_last),
        .tick_i  (state_q == ST_GAP && host_fall),
        .limit_i (GAP_W'(GAP_LIM)),
        .last_o  (gap_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept && cmd_op_i == OP_OPEN) state_d = ST_ARM;
            ST_ARM:        if (host_fall) state_d = ST_SEL;
            ST_SEL: begin
                if (take_xfer)       state_d = ST_FALL_WAIT;
                else if (take_close) state_d = ST_TAIL;
            end
            ST_FALL_WAIT:  if (host_rise) state_d = ST_DRIVE_WAIT;
            ST_DRIVE_WAIT: if (host_fall) state_d = ST_RISE_WAIT;
            ST_RISE_WAIT:  if (host_rise) state_d = ST_HOLD_WAIT;
            ST_HOLD_WAIT:  if (host_fall) state_d = bit_last ? ST_SEL : ST_FALL_WAIT;
            ST_TAIL:       if (tail_last) state_d = ST_GAP;
            ST_GAP:        if (gap_last) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sckm_o     <= 1'b1;
            csbm_o     <= 1'b1;
            sdiom_oe_o <= 1'b0;
            wr_mode_q  <= 1'b0;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            rx_valid_o <= 1'b0;
            unique case (state_q)
                ST_ARM:        if (host_fall) csbm_o <= 1'b0;
                ST_SEL:        if (take_xfer) wr_mode_q <= (cmd_op_i == OP_WRITE);
                ST_FALL_WAIT:  if (host_rise) sckm_o <= 1'b0;
                ST_DRIVE_WAIT: if (host_fall) sdiom_oe_o <= wr_mode_q;
                ST_RISE_WAIT:  if (host_rise) sckm_o <= 1'b1;
                ST_HOLD_WAIT: begin
                    if (host_fall && bit_last) begin
                        rx_valid_o <= 1'b1;
                        rx_data_o  <= rx_word;
                    end
                end
                ST_TAIL: begin
                    if (tail_last) begin
                        csbm_o     <= 1'b1;
                        sdiom_oe_o <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_cs_fall_on_host_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csbm_o) |-> $past(host_fall));

    assert_sck_on_host_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sckm_o != $past(sckm_o)) |-> $past(host_rise));

    assert_data_after_sck_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdiom_o) |-> ($past(host_fall) && !sckm_o));

    assert_rx_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_oe_off_when_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        csbm_o |-> !sdiom_oe_o);

    assert_sck_idle_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
        csbm_o |-> sckm_o);

endmodule

// File: tb/spim_host_paced_tb_top.sv
module spim_host_paced_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sck = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic cmd_ready, sckm, csbm, sdiom, sdiom_oe, rx_valid;
    logic sdiom_in = 1'b0;
    logic [7:0] rx_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spim_host_paced dut_i (
        .clk(clk), .rst_n(rst_n), .host_sck_i(host_sck),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_data_i(cmd_data),
        .cmd_ready_o(cmd_ready), .sckm_o(sckm), .csbm_o(csbm),
        .sdiom_o(sdiom), .sdiom_oe_o(sdiom_oe), .sdiom_i(sdiom_in),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // byte plan: master bytes, write flags, slave bytes
    logic [7:0] tx_byte [0:4];
    bit         tx_wr   [0:4];
    logic [7:0] sl_byte [0:4];

    // behavioural slave / edge-count model
    int hc = 0, ec = 0;
    int t_csfall = 0, t_csrise = 0, t_sckfall = 0, t_sckrise = 0;
    bit had_close = 0, first_fall = 0, skip_first = 0, any_rise = 0;
    int bi = 0, bitidx = 0, ri = 0;
    logic [7:0] cap = 0;
    logic p_sck = 1, p_cs = 1, p_sdo = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (csbm) chk(sckm && !sdiom_oe, "R12/R10 idle lines", {sckm, sdiom_oe}, 2);
            if (p_cs && !csbm) begin
                chk(ec % 2 == 0, "R2 select falls on host fall", ec % 2, 0);
                if (had_close) chk(ec - t_csrise == 6, "R9 select high gap", ec - t_csrise, 6);
                t_csfall = ec; first_fall = 1; bitidx = 0; any_rise = 0;
            end
            if (!csbm && p_sck && !sckm) begin
                chk(ec % 2 == 1, "R4 clock falls on host rise", ec % 2, 1);
                if (first_fall) begin
                    if (!skip_first) chk(ec - t_csfall == 1, "R3 select to first fall", ec - t_csfall, 1);
                    skip_first = 0;
                    first_fall = 0;
                end else begin
                    chk(ec - t_sckrise == 2, "R4 clock high period", ec - t_sckrise, 2);
                end
                t_sckfall = ec;
                sdiom_in <= sl_byte[bi][7-bitidx];
            end
            if (!csbm && !p_sck && sckm) begin
                chk(ec - t_sckfall == 2, "R4 clock low period", ec - t_sckfall, 2);
                cap = {cap[6:0], sdiom};
                bitidx++;
                t_sckrise = ec; any_rise = 1;
                if (bitidx == 8) begin
                    chk(sdiom_oe == tx_wr[bi], "R10 drive enable", sdiom_oe, tx_wr[bi]);
                    if (tx_wr[bi]) chk(cap == tx_byte[bi], "R6 msb first", cap, tx_byte[bi]);
                    bi++; bitidx = 0;
                end
            end
            if (!csbm && sdiom != p_sdo)
                chk(ec - t_sckfall == 1 && !sckm, "R5 data edge", ec - t_sckfall, 1);
            if (!p_cs && csbm) begin
                if (any_rise) chk(ec - t_sckrise == 11, "R8 tail", ec - t_sckrise, 11);
                t_csrise = ec; had_close = 1;
            end
            if (rx_valid) begin
                chk(ri < 5 && rx_data == sl_byte[ri], "R7 received byte", rx_data, sl_byte[ri % 5]);
                ri++;
            end
        end
        p_sck = sckm; p_cs = csbm; p_sdo = sdiom;
        // host clock: low 6 cycles, high 4 cycles
        hc = (hc + 1) % 10;
        if (hc == 6) begin host_sck = 1'b1; ec++; end
        if (hc == 0) begin host_sck = 1'b0; ec++; end
    end

    task automatic issue(input logic [2:0] op, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic wait_deselect();
        while (!csbm) @(negedge clk);
    endtask

    initial begin
        tx_byte[0] = 8'hA5; tx_wr[0] = 1; sl_byte[0] = 8'h5A;
        tx_byte[1] = 8'h00; tx_wr[1] = 0; sl_byte[1] = 8'hC3;
        tx_byte[2] = 8'h3C; tx_wr[2] = 1; sl_byte[2] = 8'h7E;
        tx_byte[3] = 8'h81; tx_wr[3] = 1; sl_byte[3] = 8'h18;
        tx_byte[4] = 8'h00; tx_wr[4] = 0; sl_byte[4] = 8'hE7;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(csbm && sckm && !sdiom_oe && !rx_valid && cmd_ready, "R1 reset state",
            {csbm, sckm, sdiom_oe, rx_valid, cmd_ready}, 5'b11001);

        // R11: commands illegal in idle are consumed without effect
        issue(3'd0, 8'h00);
        issue(3'd2, 8'h55);
        issue(3'd4, 8'h00);
        repeat (40) @(negedge clk);
        chk(csbm && sckm && cmd_ready && ri == 0, "R11 ignored in idle",
            {csbm, sckm, cmd_ready}, 3'b111);

        // transaction 1: write, read, write
        issue(3'd1, 8'h00);
        issue(3'd2, tx_byte[0]);
        issue(3'd3, tx_byte[1]);
        issue(3'd2, tx_byte[2]);
        issue(3'd4, 8'h00);
        wait_deselect();

        // transaction 2: open pending through the gap
        issue(3'd1, 8'h00);
        issue(3'd2, tx_byte[3]);
        issue(3'd4, 8'h00);
        wait_deselect();

        // transaction 3: second open while selected is ignored
        skip_first = 1;
        issue(3'd1, 8'h00);
        while (csbm) @(negedge clk);
        issue(3'd1, 8'h00);
        repeat (60) @(negedge clk);
        chk(!csbm && sckm && cmd_ready && bi == 4, "R11 ignored while selected",
            {csbm, sckm, cmd_ready}, 3'b011);
        issue(3'd3, tx_byte[4]);
        issue(3'd4, 8'h00);
        wait_deselect();
        repeat (20) @(negedge clk);
        chk(ri == 5, "R7 byte count", ri, 5);
        chk(bi == 5, "R6 bytes seen by slave", bi, 5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R8 watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule